// File: doc/BRIEF.md
# Digitally Trimmed One-Second Prescaler

This block turns a stream of single-cycle oscillator enables, nominally 32,768 per second, into a one-second tick and a minute strobe. The crystal is not trimmed. The rate is corrected by changing the length of selected seconds. Correction repeats over a 64-minute cycle. A 5-bit magnitude N and a sign bit choose how many minutes have their first second altered: the first 2×N minutes of the cycle. Slowing the clock makes an altered second 128 oscillator periods longer. Speeding it up makes an altered second 256 periods shorter.

A frequency-test output toggles at 512 Hz and is derived from the corrected second counter, so measuring its rate shows the residual error of the oscillator. A stop input freezes every counter. The calibration setting is captured only at the start of a minute. The cycles-per-second and seconds-per-minute counts are parameters, so a shortened configuration can be checked cycle-exactly.

Top module: `cal_prescaler`

## Requirements
- R1: With no correction in force, `secTick` pulses for one clock, in a clock where `oscTick` is high, after every `CYC_PER_SEC` oscillator ticks. The first tick after reset comes after `CYC_PER_SEC-1` further ticks, because the count starts at the release edge.
- R2: `minTick` is high exactly on every `SEC_PER_MIN`-th `secTick`, and never without `secTick`.
- R3: `calCfg[4:0]` is the magnitude N and `calCfg[5]` is the sign. Within a 64-minute cycle, only the first second of minutes 0 to 2N-1 is altered. N=0 alters nothing, and N=31 leaves minutes 62 and 63 nominal.
- R4: With sign 0, an altered second lasts `CYC_PER_SEC+128` oscillator ticks.
- R5: With sign 1, an altered second lasts `CYC_PER_SEC-256` oscillator ticks.
- R6: The minute position wraps from 63 to 0, so the correction pattern repeats every 64 minutes.
- R7: `calCfg` is captured only while the second and cycle counts are both zero at the start of a minute. A change made later in a minute has no effect until the next minute starts.
- R8: While `stopBit` is 1, no counter advances, `secTick` and `minTick` stay low and `freqTest` is low. Counting resumes where it stopped.
- R9: When `testEn` is 1 and `stopBit` is 0, `freqTest` is high while the tick index within the current second, taken modulo 64, is 32 to 63. This gives a 512 Hz square wave at the nominal rate. When `testEn` is 0, `freqTest` is low.
- R10: Reset clears all counters and the captured setting, and all outputs are low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One-clock oscillator enable |
| stopBit | input | 1 | Freezes all counting when 1 |
| testEn | input | 1 | Enables the 512 Hz test output |
| calCfg | input | 6 | [4:0] magnitude, [5] sign (1 = faster) |
| secTick | output | 1 | One-clock pulse at the end of each second |
| minTick | output | 1 | One-clock pulse on the last second of a minute |
| freqTest | output | 1 | 512 Hz test square wave |

## Verification
The assertions check on every cycle:
- every completed second has one of the three legal lengths;
- `minTick` falls only on the correct `secTick`;
- a stopped block neither ticks nor moves its count, and the test output is quiet when disabled or stopped.

Only the bench scenarios can show which seconds are altered, in which minutes, across a full 64-minute wrap. The same holds for the capture of a changed setting at the next minute boundary and for the exact phase of the test waveform inside a second.

// File: rtl/cal_prescaler_pkg.sv
package cal_prescaler_pkg;
  localparam int CAL_MAG_W = 5;
  localparam int CAL_CFG_W = CAL_MAG_W + 1;

  typedef struct packed {
    logic run;
    logic stretch;
    logic shorten;
  } presc_ctl_t;
endpackage

// File: rtl/cal_prescaler_dp.sv
module cal_prescaler_dp
  import cal_prescaler_pkg::*;
#(
  parameter int CYC_PER_SEC = 32768,
  parameter int NEG_TRIM    = 128,
  parameter int POS_TRIM    = 256,
  parameter int FT_DIV      = 64,
  localparam int CNT_W      = $clog2(CYC_PER_SEC + NEG_TRIM)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscTick,
  input  logic             testEn,
  input  presc_ctl_t       ctl,
  output logic             secDone,
  output logic             cntZero,
  output logic             freqTest,
  output logic [CNT_W-1:0] cycCnt
);
  localparam int FT_BIT = $clog2(FT_DIV) - 1;
  localparam logic [CNT_W-1:0] LAST_NOM   = CNT_W'(CYC_PER_SEC - 1);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(CYC_PER_SEC + NEG_TRIM - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(CYC_PER_SEC - POS_TRIM - 1);

  logic [CNT_W-1:0] lastIdx;
  logic             advance;

  always_comb begin
    if (ctl.shorten)      lastIdx = LAST_SHORT;
    else if (ctl.stretch) lastIdx = LAST_LONG;
    else                  lastIdx = LAST_NOM;
  end

  assign advance  = oscTick && ctl.run;
  assign secDone  = advance && (cycCnt == lastIdx);
  assign cntZero  = (cycCnt == '0);
  assign freqTest = testEn && ctl.run && cycCnt[FT_BIT];

  always_ff @(posedge clk) begin
    if (!rstN)        cycCnt <= '0;
    else if (secDone) cycCnt <= '0;
    else if (advance) cycCnt <= cycCnt + 1'b1;
  end
endmodule

// File: rtl/cal_prescaler_ctl.sv
module cal_prescaler_ctl
  import cal_prescaler_pkg::*;
#(
  parameter int SEC_PER_MIN   = 60,
  parameter int MIN_PER_CYCLE = 64,
  localparam int SEC_W        = $clog2(SEC_PER_MIN),
  localparam int MIN_W        = $clog2(MIN_PER_CYCLE)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stopBit,
  input  logic [CAL_CFG_W-1:0] calCfg,
  input  logic                 secDone,
  input  logic                 cntZero,
  output presc_ctl_t           ctl,
  output logic                 minDone
);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_CYCLE - 1);

  logic [SEC_W-1:0]     secCnt;
  logic [MIN_W-1:0]     minCnt;
  logic [CAL_MAG_W-1:0] magLat;
  logic                 signLat;
  logic                 eligible;
  logic                 firstSec;

  assign firstSec = (secCnt == '0);
  assign eligible = ({1'b0, minCnt} < {magLat, 1'b0}) && firstSec;

  assign ctl.run     = !stopBit;
  assign ctl.stretch = eligible && !signLat;
  assign ctl.shorten = eligible && signLat;
  assign minDone     = secDone && (secCnt == SEC_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      magLat  <= '0;
      signLat <= 1'b0;
    end else if (!stopBit && cntZero && firstSec) begin
      magLat  <= calCfg[CAL_MAG_W-1:0];
      signLat <= calCfg[CAL_MAG_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCnt <= '0;
      minCnt <= '0;
    end else if (secDone) begin
      if (minDone) begin
        secCnt <= '0;
        minCnt <= (minCnt == MIN_LAST) ? '0 : minCnt + 1'b1;
      end else begin
        secCnt <= secCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler
  import cal_prescaler_pkg::*;
#(
  parameter int CYC_PER_SEC = 32768,
  parameter int SEC_PER_MIN = 60,
  parameter int NEG_TRIM    = 128,
  parameter int POS_TRIM    = 256,
  parameter int FT_DIV      = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscTick,
  input  logic       stopBit,
  input  logic       testEn,
  input  logic [5:0] calCfg,
  output logic       secTick,
  output logic       minTick,
  output logic       freqTest
);
  localparam int CNT_W = $clog2(CYC_PER_SEC + NEG_TRIM);

  presc_ctl_t       ctl;
  logic             secDone;
  logic             cntZero;
  logic [CNT_W-1:0] cycCnt;

  cal_prescaler_ctl #(
    .SEC_PER_MIN  (SEC_PER_MIN),
    .MIN_PER_CYCLE(64)
  ) u_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .stopBit(stopBit),
    .calCfg (calCfg),
    .secDone(secDone),
    .cntZero(cntZero),
    .ctl    (ctl),
    .minDone(minTick)
  );

  cal_prescaler_dp #(
    .CYC_PER_SEC(CYC_PER_SEC),
    .NEG_TRIM   (NEG_TRIM),
    .POS_TRIM   (POS_TRIM),
    .FT_DIV     (FT_DIV)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .oscTick (oscTick),
    .testEn  (testEn),
    .ctl     (ctl),
    .secDone (secDone),
    .cntZero (cntZero),
    .freqTest(freqTest),
    .cycCnt  (cycCnt)
  );

  assign secTick = secDone;
endmodule

// File: rtl/cal_prescaler_chk.sv
module cal_prescaler_chk #(
  parameter int CYC_PER_SEC = 32768,
  parameter int SEC_PER_MIN = 60,
  parameter int NEG_TRIM    = 128,
  parameter int POS_TRIM    = 256,
  parameter int CNT_W       = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             oscTick,
  input logic             stopBit,
  input logic             testEn,
  input logic             secTick,
  input logic             minTick,
  input logic             freqTest,
  input logic [CNT_W-1:0] cycCnt
);
  logic [31:0] lenCnt;
  logic [31:0] secSeen;
  logic [31:0] lenNow;

  assign lenNow = lenCnt + 32'd1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenCnt  <= '0;
      secSeen <= '0;
    end else begin
      if (secTick) lenCnt <= '0;
      else if (oscTick && !stopBit) lenCnt <= lenCnt + 32'd1;
      if (secTick) secSeen <= (secSeen == SEC_PER_MIN - 1) ? '0 : secSeen + 32'd1;
    end
  end

  // R8: a stopped block never ends a second
  assert_no_tick_stopped_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopBit |-> !secTick);

  // R8: the cycle count is frozen while stopped
  assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    stopBit |=> $stable(cycCnt));

  // R2: minute strobe only together with the second tick
  assert_min_needs_sec_R2: assert property (@(posedge clk) disable iff (!rstN)
    minTick |-> secTick);

  // R2: minute strobe falls exactly on the last second of each minute
  assert_min_position_R2: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> (minTick == (secSeen == SEC_PER_MIN - 1)));

  // R4 / R5 / R1: every second has one of the three legal lengths
  assert_len_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> (lenNow == CYC_PER_SEC || lenNow == CYC_PER_SEC + NEG_TRIM ||
                 lenNow == CYC_PER_SEC - POS_TRIM));

  // R9: test output low when disabled or stopped
  assert_ft_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!testEn || stopBit) |-> !freqTest);
endmodule

bind cal_prescaler cal_prescaler_chk #(
  .CYC_PER_SEC(CYC_PER_SEC),
  .SEC_PER_MIN(SEC_PER_MIN),
  .NEG_TRIM   (NEG_TRIM),
  .POS_TRIM   (POS_TRIM),
  .CNT_W      (CNT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .oscTick (oscTick),
  .stopBit (stopBit),
  .testEn  (testEn),
  .secTick (secTick),
  .minTick (minTick),
  .freqTest(freqTest),
  .cycCnt  (cycCnt)
);

// File: tb/cal_prescaler_tb.sv
module cal_prescaler_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CYC  = 512;
  localparam int SPM  = 2;
  localparam int NEG  = 128;
  localparam int POS  = 256;
  localparam int LONG = CYC + NEG;
  localparam int SHRT = CYC - POS;

  logic clk = 1'b0;
  logic rstN, oscTick, stopBit, testEn;
  logic [5:0] calCfg;
  logic secTick, minTick, freqTest;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_prescaler #(
    .CYC_PER_SEC(CYC), .SEC_PER_MIN(SPM), .NEG_TRIM(NEG), .POS_TRIM(POS), .FT_DIV(64)
  ) u_dut (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .stopBit(stopBit), .testEn(testEn),
    .calCfg(calCfg), .secTick(secTick), .minTick(minTick), .freqTest(freqTest)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts clocks from the current negedge until a secTick is seen.
  task automatic waitTick(output int len, output bit wasMin);
    len = 0;
    forever begin
      @(negedge clk);
      len++;
      if (secTick) break;
    end
    wasMin = minTick;
  endtask

  task automatic doReset(input logic [5:0] cfg);
    @(negedge clk);
    rstN = 1'b0; oscTick = 1'b1; stopBit = 1'b0; testEn = 1'b0; calCfg = cfg;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    @(negedge clk);
    rstN = 1'b0; oscTick = 1'b1; testEn = 1'b1; stopBit = 1'b0; calCfg = 6'h1f;
    repeat (3) @(negedge clk);
    chk(!secTick && !minTick && !freqTest, "R10 outputs low in reset",
        {secTick, minTick, freqTest}, 0);
    rstN = 1'b1;
  endtask

  task automatic testNominal();
    int len; bit m;
    doReset(6'h00);
    waitTick(len, m);
    chk(len == CYC - 1, "R1 first second after reset", len, CYC - 1);
    chk(!m, "R2 no minute on first second", m, 0);
    for (int i = 0; i < 3; i++) begin
      waitTick(len, m);
      chk(len == CYC, "R1 nominal second length", len, CYC);
      chk(m == (i % 2 == 0), "R2 minute strobe position", m, (i % 2 == 0));
    end
  endtask

  task automatic testNeg1();
    int len; bit m;
    doReset(6'h01);  // sign 0, N=1 -> minutes 0 and 1 altered
    waitTick(len, m);
    chk(len == LONG - 1, "R4 stretched first second", len, LONG - 1);
    waitTick(len, m);
    chk(len == CYC, "R3 second 1 unaltered", len, CYC);
    waitTick(len, m);
    chk(len == LONG, "R4 minute 1 stretched", len, LONG);
    waitTick(len, m);
    waitTick(len, m);
    chk(len == CYC, "R3 minute 2 nominal for N=1", len, CYC);
  endtask

  task automatic testPos3();
    int len; bit m;
    doReset(6'h23);  // sign 1, N=3 -> minutes 0..5 shortened
    for (int mi = 0; mi < 7; mi++) begin
      waitTick(len, m);
      if (mi == 0) chk(len == SHRT - 1, "R5 shortened first second", len, SHRT - 1);
      else if (mi < 6) chk(len == SHRT, "R5 shortened second", len, SHRT);
      else chk(len == CYC, "R3 minute 6 nominal for N=3", len, CYC);
      waitTick(len, m);
      chk(len == CYC && m, "R3 second 1 nominal with minute", len, CYC);
    end
  endtask

  task automatic testLateChange();
    int len; bit m;
    doReset(6'h00);
    repeat (10) @(negedge clk);
    calCfg = 6'h01;  // arrives mid-minute, must wait for minute 1
    waitTick(len, m);
    chk(len == CYC - 1 - 10, "R7 late setting ignored in minute 0", len, CYC - 11);
    waitTick(len, m);
    chk(len == CYC, "R7 second 1 nominal", len, CYC);
    waitTick(len, m);
    chk(len == LONG, "R7 setting applied at minute 1", len, LONG);
  endtask

  task automatic testStop();
    int len; bit m; int badTick; int badFt;
    doReset(6'h00);
    testEn = 1'b1;
    waitTick(len, m);
    len = 0; badTick = 0; badFt = 0;
    repeat (50) begin @(negedge clk); len++; end
    stopBit = 1'b1;
    repeat (100) begin
      @(negedge clk); len++;
      if (secTick || minTick) badTick++;
      if (freqTest) badFt++;
    end
    chk(badTick == 0, "R8 no tick while stopped", badTick, 0);
    chk(badFt == 0, "R8 test output low while stopped", badFt, 0);
    stopBit = 1'b0;
    forever begin
      @(negedge clk); len++;
      if (secTick) break;
    end
    chk(len == CYC + 100, "R8 count resumes after stop", len, CYC + 100);
    testEn = 1'b0;
  endtask

  task automatic testFreq();
    int len; bit m; int bad; int exp;
    doReset(6'h00);
    testEn = 1'b1;
    waitTick(len, m);
    bad = 0;
    for (int k = 1; k <= CYC; k++) begin
      @(negedge clk);
      exp = ((k - 1) >> 5) & 1;
      if (freqTest !== exp[0]) bad++;
    end
    chk(bad == 0 && secTick, "R9 test waveform phase", bad, 0);
    testEn = 1'b0;
    bad = 0;
    repeat (CYC) begin @(negedge clk); if (freqTest) bad++; end
    chk(bad == 0, "R9 test output low when disabled", bad, 0);
  endtask

  task automatic testFullCycle();
    int len; bit m; int bad0; int bad1; int exp;
    doReset(6'h1f);  // sign 0, N=31 -> minutes 0..61 stretched
    bad0 = 0; bad1 = 0;
    for (int mi = 0; mi < 64; mi++) begin
      waitTick(len, m);
      exp = (mi < 62) ? LONG : CYC;
      if (mi == 0) exp = exp - 1;
      if (len != exp) begin
        bad0++;
        $display("FAIL R3 minute %0d actual=%0d expected=%0d", mi, len, exp);
      end
      waitTick(len, m);
      if (len != CYC || !m) bad1++;
    end
    chk(bad0 == 0, "R3 N=31 altered minute pattern", bad0, 0);
    chk(bad1 == 0, "R2 second 1 and minute strobe over cycle", bad1, 0);
    waitTick(len, m);
    chk(len == LONG, "R6 cycle wraps to minute 0", len, LONG);
  endtask

  initial begin
    rstN = 1'b0; oscTick = 1'b0; stopBit = 1'b0; testEn = 1'b0; calCfg = '0;
    testReset();
    testNominal();
    testNeg1();
    testPos3();
    testLateChange();
    testStop();
    testFreq();
    testFullCycle();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule